// File: doc/BRIEF.md
# Event Channel Enable Controller

This block keeps one enable flag for each of 32 event-interconnect channels. It also manages six channel groups, each of which can switch a set of channels on or off in a single step. Software reaches it through a simple word-addressed register port. It can turn channels on or off with write-one masks, give each group a membership mask, and fire a per-group "switch on" or "switch off" task.

Each group task can also be started by hardware. A task has a subscription register that names one channel. When that channel is enabled and carries an event pulse, the task fires exactly as a register write would. The block produces only the channel enable vector and the register readback. It does not carry events from publishers to subscribers.

Top module: `event_channel_ctrl`

## Requirements
- R1: After reset, every channel enable, every group mask and every subscription register is 0.
- R2: A write to offset 0x104 enables every channel whose data bit is 1 and leaves the other channels unchanged. Bit n controls channel n. The new state appears on `chEnable` after the write's clock edge.
- R3: A write to offset 0x108 disables every channel whose data bit is 1. A write of all ones disables every channel.
- R4: Offset 0x100 reads the enable vector, with 1 meaning enabled. Writes to it have no effect.
- R5: Group g has a read/write membership mask at offset 0x110 + 4*g. Bit n set means channel n belongs to the group, and writing 0 empties the group.
- R6: Group g has its switch-on task at 8*g and its switch-off task at 8*g + 4. Writing data with bit 0 set fires the task, and writing data with bit 0 clear does nothing. The switch-on task sets every member channel, the switch-off task clears every member channel, and non-member channels are unaffected. Task offsets read as 0.
- R7: Each task has a subscription register at its offset plus 0x80. Bits 4:0 hold the channel number and bit 31 is the enable. It reads back as {enable, zeros, channel}. Writing 0 removes the subscription.
- R8: A task whose subscription is enabled fires when the selected channel's `chEvent` bit is high in a cycle where that channel is enabled. A pulse on a disabled channel, or a pulse seen through a disabled subscription, fires nothing.
- R9: When a set request and a clear request reach the same channel in one cycle, clear wins. Requests that reach different channels in one cycle are all applied.
- R10: A group task that fires in the same cycle as a write to that group's mask uses the mask value held before the write.
- R11: Offsets not listed above read as 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for one cycle |
| addr | input | 12 | Byte offset of the register (bits 1:0 ignored) |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational readback of the register at `addr` |
| chEvent | input | 32 | Event pulse for each channel |
| chEnable | output | 32 | Enable state for each channel |

## Verification
A register write and a subscribed event can land in the same cycle. The bench provokes this in two ways. First, it writes the channel-set register while an event fires a switch-off task whose group overlaps the set mask. The overlapping channels must end up cleared, and the channels outside the overlap must end up set. Second, it rewrites a group mask while an event fires that group's task. The result must follow the mask held before the write.

// File: rtl/evc_pkg.sv
package evc_pkg;
  parameter int CH_N   = 32;
  parameter int GRP_N  = 6;
  parameter int TASK_N = 2 * GRP_N;
  parameter int DATA_W = 32;
  parameter int CH_W   = $clog2(CH_N);

  // word offsets (byte offset / 4)
  parameter int TASK_WBASE = 0;          // 0x000: on/off pairs per group
  parameter int SUB_WBASE  = 32;         // 0x080: task offset + 0x80
  parameter int STAT_WORD  = 64;         // 0x100
  parameter int SET_WORD   = 65;         // 0x104
  parameter int CLR_WORD   = 66;         // 0x108
  parameter int MASK_WBASE = 68;         // 0x110

  typedef struct packed {
    logic [GRP_N-1:0] grpOn;
    logic [GRP_N-1:0] grpOff;
    logic [GRP_N-1:0] maskWr;
    logic             setWr;
    logic             clrWr;
  } evc_strobe_t;
endpackage

// File: rtl/evc_ctrl.sv
module evc_ctrl
  import evc_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        wrEn,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [DATA_W-1:0]           wrData,
  input  logic [CH_N-1:0]             chEvent,
  input  logic [CH_N-1:0]             chEn,
  input  logic [GRP_N-1:0][CH_N-1:0]  grpMask,
  output evc_strobe_t                 strb,
  output logic [DATA_W-1:0]           rdData
);
  localparam int W = ADDR_W - 2;

  logic [W-1:0]                  wordIdx;
  logic [TASK_N-1:0]             subOn;
  logic [TASK_N-1:0][CH_W-1:0]   subCh;
  logic [TASK_N-1:0]             fire;

  assign wordIdx = addr[ADDR_W-1:2];

  for (genvar t = 0; t < TASK_N; t++) begin : g_task
    logic taskWr;
    logic evtHit;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        subOn[t] <= 1'b0;
        subCh[t] <= '0;
      end else if (wrEn && wordIdx == W'(SUB_WBASE + t)) begin
        subOn[t] <= wrData[DATA_W-1];
        subCh[t] <= wrData[CH_W-1:0];
      end
    end

    assign taskWr  = wrEn && (wordIdx == W'(TASK_WBASE + t)) && wrData[0];
    assign evtHit  = subOn[t] && chEvent[subCh[t]] && chEn[subCh[t]];
    assign fire[t] = taskWr || evtHit;
  end

  for (genvar g = 0; g < GRP_N; g++) begin : g_grp
    assign strb.grpOn[g]  = fire[2*g];
    assign strb.grpOff[g] = fire[2*g+1];
    assign strb.maskWr[g] = wrEn && (wordIdx == W'(MASK_WBASE + g));
  end

  assign strb.setWr = wrEn && (wordIdx == W'(SET_WORD));
  assign strb.clrWr = wrEn && (wordIdx == W'(CLR_WORD));

  always_comb begin
    rdData = '0;
    if (wordIdx == W'(STAT_WORD)) rdData = DATA_W'(chEn);
    for (int t = 0; t < TASK_N; t++)
      if (wordIdx == W'(SUB_WBASE + t))
        rdData = {subOn[t], (DATA_W-1-CH_W)'(0), subCh[t]};
    for (int g = 0; g < GRP_N; g++)
      if (wordIdx == W'(MASK_WBASE + g))
        rdData = DATA_W'(grpMask[g]);
  end

  // R6: task offsets always read as zero
  assert_task_rd_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wordIdx < W'(TASK_N)) |-> (rdData == '0));

  // R7: a written subscription reads back with channel and enable bit
  assert_sub_readback_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wordIdx == W'(SUB_WBASE)) |=>
      (subOn[0] == $past(wrData[DATA_W-1]) && subCh[0] == $past(wrData[CH_W-1:0])));
endmodule

// File: rtl/evc_datapath.sv
module evc_datapath
  import evc_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  evc_strobe_t                 strb,
  input  logic [DATA_W-1:0]           wrData,
  output logic [CH_N-1:0]             chEn,
  output logic [GRP_N-1:0][CH_N-1:0]  grpMask
);
  logic [CH_N-1:0] setAll;
  logic [CH_N-1:0] clrAll;

  always_comb begin
    setAll = strb.setWr ? wrData[CH_N-1:0] : '0;
    clrAll = strb.clrWr ? wrData[CH_N-1:0] : '0;
    for (int g = 0; g < GRP_N; g++) begin
      if (strb.grpOn[g])  setAll = setAll | grpMask[g];
      if (strb.grpOff[g]) clrAll = clrAll | grpMask[g];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chEn <= '0;
    else       chEn <= (chEn | setAll) & ~clrAll;
  end

  for (genvar g = 0; g < GRP_N; g++) begin : g_mask
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              grpMask[g] <= '0;
      else if (strb.maskWr[g]) grpMask[g] <= wrData[CH_N-1:0];
    end

    assert_mask_wr_R5: assert property (@(posedge clk) disable iff (!rstN)
      strb.maskWr[g] |=> (grpMask[g] == $past(wrData[CH_N-1:0])));
  end

  assert_set_applied_R2: assert property (@(posedge clk) disable iff (!rstN)
    (|(setAll & ~clrAll)) |=> ((chEn & $past(setAll & ~clrAll)) == $past(setAll & ~clrAll)));

  assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    (|clrAll) |=> ((chEn & $past(clrAll)) == '0));

  assert_untouched_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (((chEn ^ $past(chEn)) & ~$past(setAll | clrAll)) == '0));
endmodule

// File: rtl/event_channel_ctrl.sv
module event_channel_ctrl
  import evc_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  input  logic [31:0]       chEvent,
  output logic [31:0]       chEnable
);
  evc_strobe_t                strb;
  logic [GRP_N-1:0][CH_N-1:0] grpMask;

  evc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .chEvent(chEvent), .chEn(chEnable), .grpMask(grpMask),
    .strb(strb), .rdData(rdData)
  );

  evc_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .chEn(chEnable), .grpMask(grpMask)
  );
endmodule

// File: tb/event_channel_ctrl_bench.sv
module event_channel_ctrl_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [31:0] chEvent = '0;
  logic [31:0] chEnable;
  int checkCnt = 0;
  int failCnt = 0;

  always #2.5 clk = ~clk;

  event_channel_ctrl u_event_channel_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .chEvent(chEvent), .chEnable(chEnable)
  );

  typedef struct packed {
    logic [11:0] a;
    logic [31:0] d;
    logic [31:0] expEn;
    int          tag;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{12'h104, 32'h0000_00FF, 32'h0000_00FF, 2},  // R2 set
    '{12'h108, 32'h0000_000F, 32'h0000_00F0, 3},  // R3 clear
    '{12'h110, 32'h0000_0F00, 32'h0000_00F0, 5},  // R5 mask g0
    '{12'h000, 32'h0000_0001, 32'h0000_0FF0, 6},  // R6 group 0 on
    '{12'h114, 32'h0000_00C0, 32'h0000_0FF0, 5},  // R5 mask g1
    '{12'h00C, 32'h0000_0001, 32'h0000_0F30, 6},  // R6 group 1 off
    '{12'h000, 32'h0000_0000, 32'h0000_0F30, 6},  // R6 bit0 clear: no fire
    '{12'h004, 32'h0000_0001, 32'h0000_0030, 6},  // R6 group 0 off
    '{12'h100, 32'hFFFF_FFFF, 32'h0000_0030, 4},  // R4 status write ignored
    '{12'h200, 32'hFFFF_FFFF, 32'h0000_0030, 11}, // R11 unmapped write ignored
    '{12'h104, 32'hFFFF_0000, 32'hFFFF_0030, 2},  // R2 upper half
    '{12'h108, 32'hFFFF_FFFF, 32'h0000_0000, 3}   // R3 clear all
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readCheck(input logic [11:0] a, input logic [31:0] exp, input string req);
    addr = a;
    #1;
    check(rdData, exp, req);
  endtask

  task automatic pulse(input logic [31:0] ev);
    @(negedge clk);
    chEvent = ev;
    @(negedge clk);
    chEvent = '0;
  endtask

  initial begin
    #2_000_000;
    checkCnt++; failCnt++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check(chEnable, 32'h0, "R1");
    readCheck(12'h110, 32'h0, "R1");
    readCheck(12'h080, 32'h0, "R1");

    for (int i = 0; i < 12; i++) begin
      writeReg(VEC[i].a, VEC[i].d);
      #1;
      check(chEnable, VEC[i].expEn, $sformatf("R%0d", VEC[i].tag));
      readCheck(12'h100, VEC[i].expEn, "R4");
    end

    // R5 mask readback
    writeReg(12'h124, 32'hA5A5_A5A5);
    readCheck(12'h124, 32'hA5A5_A5A5, "R5");
    writeReg(12'h124, 32'h0);
    readCheck(12'h124, 32'h0, "R5");
    // R6 task read as zero, R11 unmapped read zero
    readCheck(12'h000, 32'h0, "R6");
    readCheck(12'h030, 32'h0, "R11");
    readCheck(12'h200, 32'h0, "R11");
    // R7 subscription readback
    writeReg(12'h080, 32'h8000_00E3);
    readCheck(12'h080, 32'h8000_0003, "R7");
    writeReg(12'h080, 32'h0);
    readCheck(12'h080, 32'h0, "R7");

    // R8 event-driven group on, group 2, subscribe to channel 5
    writeReg(12'h118, 32'h00F0_0000);
    writeReg(12'h090, 32'h8000_0005);
    pulse(32'h20);
    #1; check(chEnable, 32'h0, "R8 disabled channel");
    writeReg(12'h104, 32'h20);
    pulse(32'h40);
    #1; check(chEnable, 32'h20, "R8 other channel");
    pulse(32'h20);
    #1; check(chEnable, 32'h00F0_0020, "R8");
    writeReg(12'h108, 32'h00F0_0000);
    writeReg(12'h090, 32'h0000_0005);
    pulse(32'h20);
    #1; check(chEnable, 32'h20, "R8 subscription off");

    // R9 set write and event-driven group off in the same cycle
    writeReg(12'h094, 32'h8000_0005);
    @(negedge clk);
    addr = 12'h104; wrData = 32'h00F0_0100; wrEn = 1'b1; chEvent = 32'h20;
    @(negedge clk);
    wrEn = 1'b0; chEvent = '0;
    #1; check(chEnable, 32'h0000_0120, "R9");

    // R10 mask write and event-driven group off in the same cycle
    writeReg(12'h104, 32'h00F0_0001);
    #1; check(chEnable, 32'h00F0_0121, "R10 setup");
    @(negedge clk);
    addr = 12'h118; wrData = 32'h0000_0001; wrEn = 1'b1; chEvent = 32'h20;
    @(negedge clk);
    wrEn = 1'b0; chEvent = '0;
    #1; check(chEnable, 32'h0000_0121, "R10");
    readCheck(12'h118, 32'h0000_0001, "R10");

    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end
endmodule